// File: doc/BRIEF.md
# Paced Interrupt Condition Router

This block gathers single-cycle event pulses into sixteen-bit condition status words and steers every condition bit to one of eight interrupt destinations. Three event groups feed it: doorbell arrivals, which carry a sixteen-bit info value that picks one bit in one of four doorbell status words; a sixteen-bit vector of load/store unit pulses; and a sixteen-bit vector of error, reset and special-event pulses. A status bit stays set until software writes a 1 to the matching bit of that word's companion clear word.

Every condition bit has a four-bit routing field that names the destination it drives. Each destination has a read-only summary word that shows which status words hold pending bits routed to it. Each destination also has a pacing down-counter. When the CPU writes a count, the counter restarts from that count. The destination line stays low until the counter reaches zero, and pending conditions stay latched while the line is held. Software reaches everything through a word-addressed bus with a single-cycle write strobe and a combinational read.

Top module: `irqPaceRouter`

## Requirements
- R1: A cycle with `dbValid` high sets one bit in doorbell status word `dbInfo[5:4]` (bus words 0 to 3). The bit position is `dbInfo[3:0]`. `dbInfo[15:6]` has no effect. The bit reads back as set from the next cycle.
- R2: Bit j of `lsuPulse` sets bit j of status word 4. Bit j of `errPulse` sets bit j of status word 5. Both become visible in the next cycle, and a status bit never sets without its pulse.
- R3: A write to word 8+k clears those bits of status word k that are 1 in `busWdata[15:0]` and leaves the other bits unchanged. Writes to status words 0 to 5 have no effect.
- R4: If a pulse sets a bit in the same cycle that a clear write removes it, the bit ends up set.
- R5: Word 16+2k holds the routing fields for bits 0 to 7 of status word k. Word 17+2k holds them for bits 8 to 15. Bit j uses field bits [4(j mod 8)+3 : 4(j mod 8)]. Field values 0 to 7 name a destination. Values 8 to 15 route the bit nowhere.
- R6: Word 32+d reads bit k as 1 exactly when status word k holds a set bit whose routing field equals d.
- R7: A write to word 40+d loads the pacing counter of destination d with `busWdata[15:0]`, even if the counter is still running. The counter then falls by one per cycle down to zero. Reading word 40+d returns the present count.
- R8: `irqOut[d]` is high exactly when word 32+d is nonzero and the counter of destination d is zero. A held-off condition stays pending.
- R9: Writing 0 to word 40+d removes any hold-off at once, so a pending destination asserts in the next cycle.
- R10: Reset clears all status, routing and counter state. With all routing fields at zero, every condition then routes to destination 0, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busWe | input | 1 | Write strobe for one cycle |
| busAddr | input | 6 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for `busAddr` |
| dbValid | input | 1 | Doorbell arrival pulse |
| dbInfo | input | 16 | Doorbell info value |
| lsuPulse | input | 16 | Load/store unit condition pulses |
| errPulse | input | 16 | Error, reset and special-event pulses |
| irqOut | output | 8 | Destination interrupt lines |

## Verification
Two pairs of actions can land in the same cycle. The first pair is a pulse that sets a status bit and a software clear that removes it. The bench drives an error pulse on one bit while a clear write covers both that bit and an older set bit, and it expects only the older bit to go. The second pair is a counter that is still running and a fresh write to its rate word. The bench rewrites the count one cycle before the old count would expire, then confirms that the line stays low across the cycle in which it would otherwise have risen, and that it rises only after the full new count has elapsed.

// File: rtl/irqPkg.sv
package irqPkg;
  parameter int STAT_W      = 16;
  parameter int NUM_DB      = 4;
  parameter int NUM_STAT    = NUM_DB + 2;
  parameter int LSU_IDX     = NUM_DB;
  parameter int ERR_IDX     = NUM_DB + 1;
  parameter int NUM_DEST    = 8;
  parameter int FLD_W       = 4;
  parameter int FLD_PER_REG = 8;
  parameter int ROUTE_REGS  = NUM_STAT * 2;
  parameter int ADDR_W      = 6;
  parameter int DATA_W      = 32;
  parameter int INFO_W      = 16;
  parameter int BIT_SEL_W   = $clog2(STAT_W);
  parameter int DB_SEL_W    = $clog2(NUM_DB);
  parameter int DEST_SEL_W  = $clog2(NUM_DEST);
  parameter int CLR_BASE    = 8;
  parameter int ROUTE_BASE  = 16;
  parameter int DEC_BASE    = 32;
  parameter int RATE_BASE   = 40;

  typedef struct packed {
    logic [NUM_STAT-1:0]   clrHit;
    logic [ROUTE_REGS-1:0] routeWr;
    logic [NUM_DEST-1:0]   rateWr;
  } ctrlStrobe_t;
endpackage

// File: rtl/irqCtrl.sv
module irqCtrl
  import irqPkg::*;
(
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strb
);
  always_comb begin
    strb = '0;
    if (busWe) begin
      for (int k = 0; k < NUM_STAT; k++)
        if (busAddr == ADDR_W'(CLR_BASE + k)) strb.clrHit[k] = 1'b1;
      for (int r = 0; r < ROUTE_REGS; r++)
        if (busAddr == ADDR_W'(ROUTE_BASE + r)) strb.routeWr[r] = 1'b1;
      for (int d = 0; d < NUM_DEST; d++)
        if (busAddr == ADDR_W'(RATE_BASE + d)) strb.rateWr[d] = 1'b1;
    end
  end
endmodule

// File: rtl/irqPacer.sv
module irqPacer #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [RATE_W-1:0] loadVal,
  input  logic              pending,
  output logic              irqLine,
  output logic [RATE_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)                count <= '0;
    else if (load)          count <= loadVal;
    else if (count != '0)   count <= count - RATE_W'(1);
  end

  assign irqLine = pending && (count == '0);
endmodule

// File: rtl/irqDatapath.sv
module irqDatapath
  import irqPkg::*;
#(
  parameter int RATE_W = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  ctrlStrobe_t                  strb,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [DATA_W-1:0]            busWdata,
  output logic [DATA_W-1:0]            busRdata,
  input  logic                         dbValid,
  input  logic [INFO_W-1:0]            dbInfo,
  input  logic [STAT_W-1:0]            lsuPulse,
  input  logic [STAT_W-1:0]            errPulse,
  output logic [NUM_DEST-1:0]          irqOut,
  output logic [NUM_STAT*STAT_W-1:0]   statusFlat,
  output logic [NUM_DEST-1:0]          pendAny
);
  logic [STAT_W-1:0]   statReg  [NUM_STAT];
  logic [STAT_W-1:0]   setVec   [NUM_STAT];
  logic [STAT_W-1:0]   clrVec   [NUM_STAT];
  logic [DATA_W-1:0]   routeReg [ROUTE_REGS];
  logic [NUM_STAT-1:0] decodeVec[NUM_DEST];
  logic [RATE_W-1:0]   paceCnt  [NUM_DEST];

  // event capture
  always_comb begin
    for (int k = 0; k < NUM_STAT; k++) begin
      setVec[k] = '0;
      clrVec[k] = strb.clrHit[k] ? busWdata[STAT_W-1:0] : '0;
    end
    for (int k = 0; k < NUM_DB; k++)
      if (dbValid && dbInfo[BIT_SEL_W +: DB_SEL_W] == DB_SEL_W'(k))
        setVec[k] = STAT_W'(1) << dbInfo[BIT_SEL_W-1:0];
    setVec[LSU_IDX] = lsuPulse;
    setVec[ERR_IDX] = errPulse;
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NUM_STAT; k++) begin
      if (rst) statReg[k] <= '0;
      else     statReg[k] <= (statReg[k] & ~clrVec[k]) | setVec[k];
    end
  end

  // routing storage
  always_ff @(posedge clk) begin
    for (int r = 0; r < ROUTE_REGS; r++) begin
      if (rst)                  routeReg[r] <= '0;
      else if (strb.routeWr[r]) routeReg[r] <= busWdata;
    end
  end

  // per-destination summary of pending routed bits
  always_comb begin
    logic [FLD_W-1:0]  fld;
    logic [STAT_W-1:0] mask;
    for (int d = 0; d < NUM_DEST; d++) begin
      for (int k = 0; k < NUM_STAT; k++) begin
        mask = '0;
        for (int b = 0; b < STAT_W; b++) begin
          fld = routeReg[2*k + b/FLD_PER_REG][(b % FLD_PER_REG)*FLD_W +: FLD_W];
          mask[b] = (fld == FLD_W'(d));
        end
        decodeVec[d][k] = |(statReg[k] & mask);
      end
      pendAny[d] = |decodeVec[d];
    end
  end

  // pacing counters
  genvar gd;
  generate
    for (gd = 0; gd < NUM_DEST; gd++) begin : g_pace
      irqPacer #(.RATE_W(RATE_W)) u_pacer (
        .clk     (clk),
        .rst     (rst),
        .load    (strb.rateWr[gd]),
        .loadVal (busWdata[RATE_W-1:0]),
        .pending (pendAny[gd]),
        .irqLine (irqOut[gd]),
        .count   (paceCnt[gd])
      );
    end
  endgenerate

  // read view
  always_comb begin
    busRdata = '0;
    for (int k = 0; k < NUM_STAT; k++)
      if (busAddr == ADDR_W'(k)) busRdata = DATA_W'(statReg[k]);
    for (int r = 0; r < ROUTE_REGS; r++)
      if (busAddr == ADDR_W'(ROUTE_BASE + r)) busRdata = routeReg[r];
    for (int d = 0; d < NUM_DEST; d++) begin
      if (busAddr == ADDR_W'(DEC_BASE + d))  busRdata = DATA_W'(decodeVec[d]);
      if (busAddr == ADDR_W'(RATE_BASE + d)) busRdata = DATA_W'(paceCnt[d]);
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_STAT; k++)
      statusFlat[k*STAT_W +: STAT_W] = statReg[k];
  end
endmodule

// File: rtl/irqPaceRouter.sv
module irqPaceRouter
  import irqPkg::*;
#(
  parameter int RATE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                busWe,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic                dbValid,
  input  logic [INFO_W-1:0]   dbInfo,
  input  logic [STAT_W-1:0]   lsuPulse,
  input  logic [STAT_W-1:0]   errPulse,
  output logic [NUM_DEST-1:0] irqOut
);
  ctrlStrobe_t                strb;
  logic [NUM_STAT*STAT_W-1:0] statusFlat;
  logic [NUM_DEST-1:0]        pendAny;

  irqCtrl u_ctrl (
    .busWe   (busWe),
    .busAddr (busAddr),
    .strb    (strb)
  );

  irqDatapath #(.RATE_W(RATE_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .dbValid    (dbValid),
    .dbInfo     (dbInfo),
    .lsuPulse   (lsuPulse),
    .errPulse   (errPulse),
    .irqOut     (irqOut),
    .statusFlat (statusFlat),
    .pendAny    (pendAny)
  );
endmodule

// File: rtl/irqPaceChk.sv
module irqPaceChk
  import irqPkg::*;
#(
  parameter int RATE_W = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       busWe,
  input logic [ADDR_W-1:0]          busAddr,
  input logic [DATA_W-1:0]          busWdata,
  input logic [STAT_W-1:0]          lsuPulse,
  input logic [STAT_W-1:0]          errPulse,
  input logic [NUM_STAT*STAT_W-1:0] statusFlat,
  input logic [NUM_DEST-1:0]        pendAny,
  input logic [NUM_DEST-1:0]        irqOut
);
  logic [STAT_W-1:0] errStat;
  logic [STAT_W-1:0] lsuStat;
  logic              rateWrNz;
  assign errStat  = statusFlat[ERR_IDX*STAT_W +: STAT_W];
  assign lsuStat  = statusFlat[LSU_IDX*STAT_W +: STAT_W];
  assign rateWrNz = busWe && (busAddr >= ADDR_W'(RATE_BASE)) &&
                    (busAddr < ADDR_W'(RATE_BASE + NUM_DEST)) &&
                    (busWdata[RATE_W-1:0] != '0);

  AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (errPulse != '0) |=> ((errStat & $past(errPulse)) == $past(errPulse))); // R4

  AST_NO_PHANTOM_SET: assert property (@(posedge clk) disable iff (rst)
    (errPulse == '0) |=> ((errStat & ~$past(errStat)) == '0)); // R2

  AST_LSU_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (busWe && busAddr == ADDR_W'(CLR_BASE + LSU_IDX) && lsuPulse == '0)
      |=> ((lsuStat & $past(busWdata[STAT_W-1:0])) == '0)); // R3

  AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busWe && busAddr == ADDR_W'(ERR_IDX) && errPulse == '0) |=> $stable(errStat)); // R3

  AST_OUT_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
    (irqOut & ~pendAny) == '0); // R8

  AST_PACE_HOLD: assert property (@(posedge clk) disable iff (rst)
    rateWrNz |=> (irqOut[$past(busAddr[DEST_SEL_W-1:0])] == 1'b0)); // R7
endmodule

bind irqPaceRouter irqPaceChk #(.RATE_W(RATE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busWe      (busWe),
  .busAddr    (busAddr),
  .busWdata   (busWdata),
  .lsuPulse   (lsuPulse),
  .errPulse   (errPulse),
  .statusFlat (statusFlat),
  .pendAny    (pendAny),
  .irqOut     (irqOut)
);

// File: tb/sim_irqPaceRouter.sv
module sim_irqPaceRouter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busWe = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        dbValid = 1'b0;
  logic [15:0] dbInfo = '0;
  logic [15:0] lsuPulse = '0;
  logic [15:0] errPulse = '0;
  logic [7:0]  irqOut;
  int nChecks = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  irqPaceRouter u0 (
    .clk(clk), .rst(rst), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .dbValid(dbValid), .dbInfo(dbInfo), .lsuPulse(lsuPulse),
    .errPulse(errPulse), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = 6'(a); busWdata = d;
    @(posedge clk); #1;
    busWe = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    busAddr = 6'(a); #1;
    d = busRdata;
  endtask

  task automatic pulse(input logic db, input logic [15:0] info,
                       input logic [15:0] lsu, input logic [15:0] err);
    @(negedge clk);
    dbValid = db; dbInfo = info; lsuPulse = lsu; errPulse = err;
    @(posedge clk); #1;
    dbValid = 1'b0; dbInfo = '0; lsuPulse = '0; errPulse = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    check("R10 irqOut", 32'(irqOut), 32'h0);
    rd(5, v);  check("R10 err status", v, 32'h0);
    rd(32, v); check("R10 decode0", v, 32'h0);
    rd(40, v); check("R10 rate0", v, 32'h0);
  endtask

  task automatic t_doorbell();
    logic [31:0] v;
    pulse(1'b1, 16'h0023, '0, '0);
    @(negedge clk); rd(2, v); check("R1 db word2 bit3", v, 32'h0008);
    pulse(1'b1, 16'hFF31, '0, '0);
    @(negedge clk); rd(3, v); check("R1 db word3 bit1 upper ignored", v, 32'h0002);
    rd(32, v); check("R6 decode0 default route", v, 32'h000C);
    check("R8 irqOut dest0", 32'(irqOut), 32'h01);
  endtask

  task automatic t_lsuErr();
    logic [31:0] v;
    pulse(1'b0, '0, 16'h0104, 16'h8001);
    @(negedge clk);
    rd(4, v); check("R2 lsu status", v, 32'h0104);
    rd(5, v); check("R2 err status", v, 32'h8001);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(10, 32'h0008);
    @(negedge clk); rd(2, v); check("R3 clear word2", v, 32'h0);
    wr(3, 32'hFFFF);
    @(negedge clk); rd(3, v); check("R3 status write ignored", v, 32'h0002);
    wr(13, 32'h0);
    @(negedge clk); rd(5, v); check("R3 zero clear keeps", v, 32'h8001);
  endtask

  task automatic t_setWins();
    logic [31:0] v;
    @(negedge clk);
    errPulse = 16'h0010; busWe = 1'b1; busAddr = 6'd13; busWdata = 32'h0011;
    @(posedge clk); #1;
    errPulse = '0; busWe = 1'b0;
    @(negedge clk); rd(5, v); check("R4 set beats clear", v, 32'h8010);
  endtask

  task automatic t_route();
    logic [31:0] v;
    for (int k = 8; k < 14; k++) wr(k, 32'hFFFF);
    @(negedge clk);
    rd(32, v); check("R3 all cleared decode0", v, 32'h0);
    check("R8 idle irqOut", 32'(irqOut), 32'h0);
    wr(24, 32'h0000_003F);
    wr(25, 32'h0000_0060);
    pulse(1'b0, '0, 16'h0001, '0);
    @(negedge clk);
    rd(32, v); check("R5 disabled field no decode", v, 32'h0);
    check("R5 disabled field no irq", 32'(irqOut), 32'h0);
    pulse(1'b0, '0, 16'h0002, '0);
    @(negedge clk);
    rd(35, v); check("R6 decode3", v, 32'h10);
    check("R8 irqOut dest3", 32'(irqOut), 32'h08);
    pulse(1'b0, '0, 16'h0200, '0);
    @(negedge clk);
    rd(38, v); check("R5 second route word decode6", v, 32'h10);
    check("R8 irqOut dest3+6", 32'(irqOut), 32'h48);
  endtask

  task automatic t_pace();
    logic [31:0] v;
    wr(43, 32'd5);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (i == 0) begin
        rd(43, v); check("R7 count readback", v, 32'd5);
        check("R7 other dest unaffected", 32'(irqOut[6]), 32'h1);
      end
      check("R7 held low", 32'(irqOut[3]), 32'h0);
    end
    @(negedge clk);
    check("R8 release after count", 32'(irqOut[3]), 32'h1);
    rd(35, v); check("R8 pending latched", v, 32'h10);
  endtask

  task automatic t_zero();
    wr(43, 32'd7);
    @(negedge clk); check("R7 hold before disable", 32'(irqOut[3]), 32'h0);
    wr(43, 32'd0);
    @(negedge clk); check("R9 zero write releases", 32'(irqOut[3]), 32'h1);
  endtask

  task automatic t_restart();
    wr(46, 32'd3);
    @(negedge clk); check("R7 low cnt3", 32'(irqOut[6]), 32'h0);
    @(negedge clk); check("R7 low cnt2", 32'(irqOut[6]), 32'h0);
    wr(46, 32'd3);
    @(negedge clk); check("R7 restart holds", 32'(irqOut[6]), 32'h0);
    @(negedge clk); check("R7 restart holds 2", 32'(irqOut[6]), 32'h0);
    @(negedge clk); check("R7 restart holds 1", 32'(irqOut[6]), 32'h0);
    @(negedge clk); check("R8 restart release", 32'(irqOut[6]), 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail + 1, nChecks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_doorbell();
    t_lsuErr();
    t_clear();
    t_setWins();
    t_route();
    t_pace();
    t_zero();
    t_restart();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule